// File: doc/BRIEF.md
# Transmit Deferral Event Counter

This block sits beside a MAC transmitter and counts how often a frame that is ready to go is held back. The MAC supplies its status as plain inputs: whether transmit is enabled, whether a frame is pending, whether the medium is busy, whether the inter-packet gap has elapsed, duplex mode, whether a received pause (XOFF) frame is holding transmission, link state, and whether the current frame follows another in a back-to-back stream. The block does not time gaps or pauses itself.

A frame that meets any blocking cause is counted once, on the first cycle it is seen blocked, however long the stall lasts. A stall caused only by the inter-packet gap while streaming back-to-back in full duplex is not a deferral. The count saturates at all-ones. A read strobe returns the current value on the output and clears the counter. If an event lands in the same cycle, that event is kept as the new value.

Top module: `txdefer_counter`

## Requirements
- R1: A synchronous active-high reset sets the count to zero and clears the record that the pending frame was already counted. A frame still pending and blocked after reset is counted again.
- R2: A pending frame that meets a busy medium counts as one deferral.
- R3: A pending frame held only because the inter-packet gap has not elapsed counts as a deferral when the streaming indicator is low.
- R4: A pending frame held by a received pause or by the link being down counts as a deferral.
- R5: In half-duplex mode (half_dup_i = 1) a gap-only stall counts even when the streaming indicator is high.
- R6: In full duplex with the streaming indicator high, a gap-only stall does not count. The same stall counts if any other blocking cause is also present.
- R7: While tx_en_i is low the count does not change. A frame still pending and blocked once transmit is enabled is then counted.
- R8: Each pending frame adds at most one. Dropping frame_pend_i for at least one cycle marks the end of that frame, so a later pending frame can count again.
- R9: The count saturates at 2^CNT_W-1 and never wraps.
- R10: In a cycle with rd_i high, count_o shows the value being read. The next value is zero, or one if a deferral event occurs in that same cycle.
- R11: The count rises by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tx_en_i | input | 1 | Transmit enabled |
| frame_pend_i | input | 1 | A frame is ready to start; drops when the frame is taken |
| medium_busy_i | input | 1 | Another station holds the medium |
| ipg_done_i | input | 1 | Inter-packet gap has elapsed |
| half_dup_i | input | 1 | 1 = half duplex, 0 = full duplex |
| xoff_paused_i | input | 1 | Transmission paused by a received XOFF |
| link_up_i | input | 1 | Link is up |
| streaming_i | input | 1 | Pending frame follows the previous one back to back |
| rd_i | input | 1 | Read strobe: return count and clear |
| count_o | output | CNT_W | Current deferral count |

## Verification
Saturation is the hardest state to reach from the ports, because a full-width counter would need billions of separate frames. The bench therefore builds the block with a narrow counter and cycles more frames than the ceiling through block/idle pairs. It also drives a read in the same cycle as a fresh deferral, and it applies reset while a counted frame is still pending. These cover the two cases where the per-frame flag and the clear path interact.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

    // Causes that can hold back a pending frame
    typedef struct packed {
        logic carrier;    // medium held by another station
        logic pause;      // received XOFF in force
        logic link_down;  // no link
        logic gap;        // inter-packet gap still running (and not exempt)
    } block_t;

    localparam int unsigned NUM_CAUSES = $bits(block_t);

endpackage

// File: rtl/txdefer_cause.sv
module txdefer_cause
    import txdefer_pkg::*;
(
    input  logic   frame_pend_i,
    input  logic   medium_busy_i,
    input  logic   ipg_done_i,
    input  logic   half_dup_i,
    input  logic   xoff_paused_i,
    input  logic   link_up_i,
    input  logic   streaming_i,
    output block_t why_o,
    output logic   blocked_o
);

    always_comb begin
        why_o.carrier   = medium_busy_i;
        why_o.pause     = xoff_paused_i;
        why_o.link_down = !link_up_i;
        // Gap stalls are exempt only for full-duplex back-to-back streams
        why_o.gap       = !ipg_done_i && (half_dup_i || !streaming_i);
        blocked_o       = frame_pend_i && (|why_o);
    end

endmodule

// File: rtl/txdefer_once.sv
module txdefer_once (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tx_en_i,
    input  logic frame_pend_i,
    input  logic blocked_i,
    output logic evt_o
);

    typedef struct packed {
        logic counted;
    } once_t;

    once_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = tx_en_i && blocked_i && !st_q.counted;
        if (!frame_pend_i) begin
            st_d.counted = 1'b0;
        end else if (evt_o) begin
            st_d.counted = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/txdefer_sat_cnt.sv
module txdefer_sat_cnt #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = inc_i ? CNT_ONE : '0;
        end else if (inc_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/txdefer_counter.sv
module txdefer_counter
    import txdefer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tx_en_i,
    input  logic             frame_pend_i,
    input  logic             medium_busy_i,
    input  logic             ipg_done_i,
    input  logic             half_dup_i,
    input  logic             xoff_paused_i,
    input  logic             link_up_i,
    input  logic             streaming_i,
    input  logic             rd_i,
    output logic [CNT_W-1:0] count_o
);

    block_t why_w;
    logic   blocked_w;
    logic   evt_w;

    txdefer_cause u_cause (
        .frame_pend_i  (frame_pend_i),
        .medium_busy_i (medium_busy_i),
        .ipg_done_i    (ipg_done_i),
        .half_dup_i    (half_dup_i),
        .xoff_paused_i (xoff_paused_i),
        .link_up_i     (link_up_i),
        .streaming_i   (streaming_i),
        .why_o         (why_w),
        .blocked_o     (blocked_w)
    );

    txdefer_once u_once (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tx_en_i      (tx_en_i),
        .frame_pend_i (frame_pend_i),
        .blocked_i    (blocked_w),
        .evt_o        (evt_w)
    );

    txdefer_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .inc_i (evt_w),
        .clr_i (rd_i),
        .cnt_o (count_o)
    );

endmodule

// File: rtl/txdefer_checks.sv
module txdefer_checks #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             tx_en_i,
    input logic             frame_pend_i,
    input logic             medium_busy_i,
    input logic             ipg_done_i,
    input logic             half_dup_i,
    input logic             xoff_paused_i,
    input logic             link_up_i,
    input logic             streaming_i,
    input logic             rd_i,
    input logic             evt_i,
    input logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_disabled_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tx_en_i && !rd_i) |=> $stable(count_o));

    assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_o == CNT_MAX && !rd_i) |=> (count_o == CNT_MAX));

    assert_read_clear_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !evt_i) |=> (count_o == '0));

    assert_read_keep_evt_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && evt_i) |=> (count_o == CNT_ONE));

    assert_once_per_frame_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> !evt_i);

    assert_step_one_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_ONE));

    assert_stream_exempt_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (streaming_i && !half_dup_i && !medium_busy_i && !xoff_paused_i && link_up_i)
        |-> !evt_i);

    assert_pend_needed_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_pend_i |-> !evt_i);

endmodule

bind txdefer_counter txdefer_checks #(.CNT_W(CNT_W)) u_txdefer_checks (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .tx_en_i       (tx_en_i),
    .frame_pend_i  (frame_pend_i),
    .medium_busy_i (medium_busy_i),
    .ipg_done_i    (ipg_done_i),
    .half_dup_i    (half_dup_i),
    .xoff_paused_i (xoff_paused_i),
    .link_up_i     (link_up_i),
    .streaming_i   (streaming_i),
    .rd_i          (rd_i),
    .evt_i         (evt_w),
    .count_o       (count_o)
);

// File: tb/txdefer_counter_bench.sv
`timescale 1ns/1ps
module txdefer_counter_bench;

    localparam int unsigned W = 4;
    localparam int unsigned NV = 26;

    logic clk = 1'b0;
    logic rst;
    logic en, pend, busy, gapok, half, pause, link, strm, rd;
    logic [W-1:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txdefer_counter #(.CNT_W(W)) u_txdefer_counter (
        .clk_i(clk), .rst_i(rst), .tx_en_i(en), .frame_pend_i(pend),
        .medium_busy_i(busy), .ipg_done_i(gapok), .half_dup_i(half),
        .xoff_paused_i(pause), .link_up_i(link), .streaming_i(strm),
        .rd_i(rd), .count_o(count)
    );

    // {en,pend,busy,ipg_done,half,pause,link,strm,rd} , expected count after the edge
    localparam logic [12:0] VEC [NV] = '{
        {9'b1_0_0_1_0_0_1_0_0, 4'd0},  // idle, R1
        {9'b1_1_1_1_0_0_1_0_0, 4'd1},  // busy medium, R2
        {9'b1_1_1_1_0_0_1_0_0, 4'd1},  // same frame still stalled, R8
        {9'b1_1_0_1_0_0_1_0_0, 4'd1},  // frame starts, R8
        {9'b1_0_0_1_0_0_1_0_0, 4'd1},  // frame taken
        {9'b1_1_0_0_0_0_1_0_0, 4'd2},  // gap only, not streaming, R3
        {9'b1_0_0_1_0_0_1_0_0, 4'd2},
        {9'b1_1_0_1_0_1_1_0_0, 4'd3},  // XOFF pause, R4
        {9'b1_0_0_1_0_0_1_0_0, 4'd3},
        {9'b1_1_0_1_0_0_0_0_0, 4'd4},  // link down, R4
        {9'b1_0_0_1_0_0_1_0_0, 4'd4},
        {9'b1_1_0_0_0_0_1_1_0, 4'd4},  // streaming gap, full duplex, R6
        {9'b1_0_0_1_0_0_1_0_0, 4'd4},
        {9'b1_1_0_0_1_0_1_1_0, 4'd5},  // streaming gap, half duplex, R5
        {9'b1_0_0_1_0_0_1_0_0, 4'd5},
        {9'b1_1_1_0_0_0_1_1_0, 4'd6},  // streaming gap plus busy, R6
        {9'b1_0_0_1_0_0_1_0_0, 4'd6},
        {9'b0_1_1_1_0_0_1_0_0, 4'd6},  // disabled, R7
        {9'b0_1_1_1_0_0_1_0_0, 4'd6},  // disabled, R7
        {9'b1_1_1_1_0_0_1_0_0, 4'd7},  // enabled, same frame counts, R7
        {9'b1_0_0_1_0_0_1_0_0, 4'd7},
        {9'b1_1_1_1_0_0_1_0_1, 4'd1},  // read with event, R10
        {9'b1_0_0_1_0_0_1_0_0, 4'd1},
        {9'b1_0_0_1_0_0_1_0_1, 4'd0},  // read clears, R10
        {9'b0_0_0_1_0_0_1_0_1, 4'd0},  // read while disabled, R10
        {9'b1_1_0_1_0_1_1_0_0, 4'd1}   // pause again, R4
    };

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {en, pend, busy, gapok, half, pause, link, strm, rd} = v;
    endtask

    // drive at negedge, let one edge pass, sample at the following negedge
    task automatic step(input logic [8:0] v);
        drive(v);
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [8:0] IDLE  = 9'b1_0_0_1_0_0_1_0_0;
    localparam logic [8:0] BUSY  = 9'b1_1_1_1_0_0_1_0_0;
    localparam logic [8:0] READ  = 9'b1_0_0_1_0_0_1_0_1;

    initial begin
        rst = 1'b1;
        drive(IDLE);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset value", count, '0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12:4]);
            check($sformatf("vector %0d", i), count, VEC[i][3:0]);
        end

        // R9: saturation with more frames than the ceiling
        step(READ);
        for (int i = 0; i < 20; i++) begin
            step(BUSY);
            step(IDLE);
            check("R11 one per frame", count, (i < 15) ? W'(i + 1) : W'(15));
        end
        check("R9 saturated", count, 4'd15);

        // R10: read shows saturated value in the strobe cycle, then clears
        drive(READ);
        #1;
        check("R10 read value", count, 4'd15);
        @(posedge clk);
        @(negedge clk);
        check("R10 cleared", count, '0);

        // R1: reset during a counted, still-pending frame
        step(BUSY);
        check("R2 busy counted", count, 4'd1);
        rst = 1'b1;
        step(BUSY);
        check("R1 reset clears", count, '0);
        rst = 1'b0;
        step(BUSY);
        check("R1 flag cleared, frame recounted", count, 4'd1);
        step(BUSY);
        check("R8 held frame", count, 4'd1);
        step(IDLE);

        // R8: back-to-back frames separated by one idle cycle
        step(BUSY);
        step(IDLE);
        step(BUSY);
        check("R8 new frame counts", count, 4'd3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule